// File: doc/BRIEF.md
# Registered Stream Slice with Skid Entry

This block is one stage of a valid/ready stream. It breaks every long timing path that crosses it. The forward valid and data come straight from flops. The upstream ready also comes from a flop, so it is never computed from downstream ready in the same cycle.

A registered ready reaches the sender one cycle late. Because of that, one beat can arrive after the downstream side has stalled. A one-entry skid register catches that beat, so nothing is lost. When the downstream side is always ready, the stage moves one beat per clock. The order of beats is kept exactly. No beat is dropped and none is repeated.

The stage is placed between a producer and a consumer that both follow the usual rule: a beat moves on a clock edge where both valid and ready are high.

Top module: `stream_reg_slice`

## Requirements
- R1: While `rstN` is low at a clock edge, all state clears. This holds `outValid` low, `inReady` low and `outData` at zero.
- R2: `inReady` is low in the first cycle after reset is released and goes high one cycle later.
- R3: Every beat accepted upstream (`inValid` and `inReady` high at an edge) leaves downstream (`outValid` and `outReady` high at an edge) exactly once, in the order it was accepted.
- R4: With `outReady` held high and `inValid` held high, one beat is accepted and one beat is delivered on every clock, and `inReady` stays high.
- R5: A beat accepted while the output register is empty or draining shows up on `outValid` in the very next cycle, never in the cycle it is accepted.
- R6: While `outValid` is high and `outReady` is low, the next cycle still shows `outValid` high with `outData` unchanged.
- R7: When a beat is accepted while the output is held (`outValid` high, `outReady` low), it goes into the skid entry and `inReady` is low in the next cycle. With the output stalled, at most two beats are accepted in total.
- R8: When `inReady` is low and `outReady` is high, `inReady` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Upstream beat present |
| inData | input | DATA_W | Upstream beat payload |
| inReady | output | 1 | Registered acceptance to the upstream side |
| outValid | output | 1 | Registered downstream beat present |
| outData | output | DATA_W | Registered downstream payload |
| outReady | input | 1 | Downstream side takes the beat |

## Verification
The assertions assume that the producer keeps `inValid` high with the same data until the beat is accepted. This is what lets the output and skid flags be judged from the ports alone. The bench driver respects that rule: when an offered beat is not taken, it holds both valid and payload and ignores the new random choice. `outReady` is assumed to be free of any rule, so the bench drives it at random every cycle, including long low stretches that fill the skid entry.

// File: rtl/slice_pkg.sv
package slice_pkg;

  // Strobes passed from the control flags to the data registers
  typedef struct packed {
    logic loadOut;      // output data register takes a new value
    logic outFromSkid;  // that value comes from the skid entry
    logic captureSkid;  // skid entry takes the incoming payload
  } slice_strobe_t;

endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output slice_strobe_t strobe
);

  logic outValidQ;
  logic skidValidQ;
  logic readyQ;

  logic accept;
  logic outFree;
  logic capture;
  logic skidNext;
  logic outValidNext;

  // A beat enters this cycle
  assign accept  = inValid & readyQ;
  // Output register may change: empty, or its beat leaves now
  assign outFree = ~outValidQ | outReady;
  // Incoming beat cannot go to the output, so park it
  assign capture = accept & ~outFree;

  always_comb begin
    if (outFree) begin
      skidNext     = 1'b0;
      outValidNext = skidValidQ | accept;
    end else begin
      skidNext     = skidValidQ | capture;
      outValidNext = outValidQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ  <= 1'b0;
      skidValidQ <= 1'b0;
      readyQ     <= 1'b0;
    end else begin
      outValidQ  <= outValidNext;
      skidValidQ <= skidNext;
      readyQ     <= ~skidNext;
    end
  end

  assign strobe.loadOut     = outFree & (skidValidQ | accept);
  assign strobe.outFromSkid = skidValidQ;
  assign strobe.captureSkid = capture;

  assign inReady  = readyQ;
  assign outValid = outValidQ;

endmodule

// File: rtl/slice_dpath.sv
module slice_dpath
  import slice_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  slice_strobe_t     strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] outDataQ;
  logic [DATA_W-1:0] skidDataQ;
  logic [DATA_W-1:0] loadValue;

  assign loadValue = strobe.outFromSkid ? skidDataQ : inData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outDataQ <= '0;
    end else if (strobe.loadOut) begin
      outDataQ <= loadValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skidDataQ <= '0;
    end else if (strobe.captureSkid) begin
      skidDataQ <= inData;
    end
  end

  assign outData = outDataQ;

endmodule

// File: rtl/stream_reg_slice.sv
module stream_reg_slice
  import slice_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  slice_strobe_t strobe;

  slice_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  slice_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/stream_reg_slice_checker.sv
module stream_reg_slice_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady
);

  a_r2_ready_low_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !inReady);

  a_r4_ready_holds_when_draining: assert property (@(posedge clk) disable iff (!rstN)
    inReady && outReady |=> inReady);

  a_r5_accept_reaches_output: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (!outValid || outReady) |=> outValid);

  a_r6_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  a_r7_skid_blocks_ready: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && outValid && !outReady |=> !inReady);

  a_r8_ready_returns: assert property (@(posedge clk) disable iff (!rstN)
    !inReady && outReady |=> inReady);

endmodule

bind stream_reg_slice stream_reg_slice_checker #(.DATA_W(DATA_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData),
  .outReady (outReady)
);

// File: tb/stream_reg_slice_test.sv
module stream_reg_slice_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         inReady;
  logic         outValid;
  logic [W-1:0] outData;
  logic         outReady = 1'b0;

  int           checks = 0;
  int           fails = 0;
  int           popCount = 0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] nextVal = 16'h0100;
  bit           inReset = 1'b1;
  bit           pending = 1'b0;
  bit           expectOut = 1'b0;
  bit           firstAccept = 1'b1;
  bit           prevStall = 1'b0;
  logic [W-1:0] prevData = '0;

  always #5 clk = ~clk;

  stream_reg_slice #(.DATA_W(W)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .inReady  (inReady),
    .outValid (outValid),
    .outData  (outData),
    .outReady (outReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one cycle. Inputs change at negedge; the handshake is judged 1 ns later.
  task automatic step(input bit v, input bit r, output bit acc);
    @(negedge clk);
    if (!pending) begin
      inValid = v;
      if (v) inData = nextVal;
    end
    outReady = r;
    #1;
    if (expectOut) check(outValid == 1'b1, "R5", "beat not on output next cycle", outValid, 1);
    acc = inValid && inReady;
    expectOut = acc && (!outValid || outReady);
    if (acc) begin
      if (firstAccept) begin
        check(outValid == 1'b0, "R5", "output valid in accept cycle", outValid, 0);
        firstAccept = 1'b0;
      end
      expQ.push_back(inData);
      nextVal = nextVal + 16'd1;
      pending = 1'b0;
    end else begin
      pending = inValid;
    end
  endtask

  task automatic drain();
    bit acc;
    int guard;
    guard = 0;
    while ((pending || expQ.size() != 0 || outValid) && guard < 100) begin
      step(1'b0, 1'b1, acc);
      guard++;
    end
    step(1'b0, 1'b1, acc);
  endtask

  // Monitor: pops the scoreboard when a beat leaves downstream
  always @(negedge clk) begin
    #2;
    if (inReset) begin
      prevStall = 1'b0;
    end else begin
      if (prevStall)
        check(outValid && outData == prevData, "R6", "stalled output changed", outData, prevData);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected beat", outData, 0);
        end else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(outData == e, "R3", "beat order", outData, e);
        end
        popCount++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit acc;
    int cnt;
    int base;

    // R1: state while reset is applied
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(inReady == 1'b0, "R1", "inReady in reset", inReady, 0);
    check(outData == '0, "R1", "outData in reset", outData, 0);

    // R2: ready rises one cycle after release
    @(negedge clk);
    rstN = 1'b1;
    inReset = 1'b0;
    #1;
    check(inReady == 1'b0, "R2", "inReady right after release", inReady, 0);
    @(negedge clk);
    #1;
    check(inReady == 1'b1, "R2", "inReady one cycle later", inReady, 1);

    // R3 random valid / ready patterns
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0), acc);
    end
    for (int i = 0; i < 1000; i++) begin
      step(($urandom_range(0, 1) != 0), ($urandom_range(0, 4) == 0), acc);
    end
    drain();

    // R4: full throughput with downstream always ready
    base = popCount;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b1, acc);
      check(inReady == 1'b1, "R4", "ready dropped in streaming", inReady, 1);
      if (acc) cnt++;
    end
    check(cnt == 40, "R4", "accepted beats", cnt, 40);
    step(1'b0, 1'b1, acc);
    step(1'b0, 1'b1, acc);
    #2;
    check(popCount - base == 40, "R4", "delivered beats", popCount - base, 40);
    drain();

    // R7: stall with continuous offer; only output reg and skid fill
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, acc);
      if (acc) cnt++;
    end
    check(cnt == 2, "R7", "beats accepted under stall", cnt, 2);
    check(inReady == 1'b0, "R7", "ready with skid full", inReady, 0);

    // R8: downstream ready again -> upstream ready next cycle
    step(1'b1, 1'b1, acc);
    check(acc == 1'b0, "R8", "accept while skid full", acc, 0);
    step(1'b1, 1'b1, acc);
    check(inReady == 1'b1, "R8", "ready after drain cycle", inReady, 1);
    drain();

    #2;
    check(expQ.size() == 0, "R3", "beats left undelivered", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule